// File: doc/BRIEF.md
# Decimal Subtractor with Inverted-Minuend Datapath

This block subtracts one packed 8421 BCD magnitude from another using one 4-bit binary adder per decimal digit. It never forms the nine's complement of the subtrahend. Instead, when subtracting, each minuend digit is bit-inverted before the adder, and each corrected sum digit is bit-inverted again on the way out. The only correction is the ordinary add-six step of a decimal adder.

Each digit's decimal carry ripples into the next digit, least significant digit first. When the subtract control is low, the inversions are off and the same datapath adds the two BCD numbers. Results and the carry flag are registered once.

In subtract mode, the top digit's carry marks that the subtrahend was larger than the minuend. The digits then hold the ten's complement of the magnitude. A later stage uses the flag to recomplement the result and to fix the sign.

Top module: `bcd_mc_sub`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` and `carry_flag` become zero at that edge.
- R2: Outputs change only at a rising clock edge. After each edge they reflect the inputs sampled at that edge, which is a latency of one cycle.
- R3: With `sub` = 1 and subtrahend ≤ minuend (but not equal), `result` is minuend − subtrahend in packed BCD and `carry_flag` is 0.
- R4: With `sub` = 1 and subtrahend > minuend, `carry_flag` is 1 and `result` is 10^DIGITS − (subtrahend − minuend). This is the ten's complement of the magnitude.
- R5: With `sub` = 1 and equal operands, `result` is all zero digits and `carry_flag` is 0.
- R6: With `sub` = 0, `result` is (minuend + subtrahend) mod 10^DIGITS. `carry_flag` is 1 exactly when the sum reaches 10^DIGITS.
- R7: A borrow propagates through any run of zero digits. For example, 1000 − 0001 gives 0999 with `carry_flag` 0.
- R8: For valid BCD inputs, every 4-bit digit of `result` lies in 0..9. Digit i occupies bits 4i+3..4i, and digit 0 is the least significant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sub | input | 1 | 1 = subtract subtrahend from minuend, 0 = add |
| minuend | input | 4*DIGITS | Packed BCD minuend (first operand) |
| subtrahend | input | 4*DIGITS | Packed BCD subtrahend (second operand) |
| result | output | 4*DIGITS | Registered packed BCD result |
| carry_flag | output | 1 | Registered top-digit carry: subtrahend > minuend when subtracting, decimal overflow when adding |

## Verification
The assertions assume that every operand digit is a legal BCD code, 0 to 9. Each data property is guarded by a validity test on the sampled inputs, so a hex digit can never trigger one. The assertions also rely on packed BCD magnitudes ordering the same way as unsigned binary, which lets the carry-flag property compare the raw operand vectors. The stimulus keeps within these assumptions: the single-digit build is driven exhaustively over the digits 0 to 9. The four-digit build draws operands as integers below 10^4 and converts them to BCD before applying them.

// File: rtl/bcd_mc_pkg.sv
package bcd_mc_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;

  function automatic logic digit_ok(input digit_t d);
    return d <= 4'd9;
  endfunction
endpackage

// File: rtl/bcd_mc_digit.sv
module bcd_mc_digit
  import bcd_mc_pkg::*;
(
  input  logic   sub_i,
  input  digit_t m_i,
  input  digit_t s_i,
  input  logic   c_i,
  output digit_t d_o,
  output logic   c_o
);
  digit_t     m_sel;
  logic [4:0] raw;
  logic       over9;
  logic       dec_c;
  digit_t     fixed;

  always_comb begin
    // selective inversion of the minuend when subtracting
    m_sel = m_i ^ {DIGIT_W{sub_i}};
    raw   = {1'b0, m_sel} + {1'b0, s_i} + {4'b0, c_i};
    over9 = raw[3] & (raw[2] | raw[1]);
    // subtract mode decides on the binary carry alone
    dec_c = raw[4] | (~sub_i & over9);
    fixed = raw[3:0] + (dec_c ? 4'd6 : 4'd0);
    d_o   = fixed ^ {DIGIT_W{sub_i}};
    c_o   = dec_c;
  end

  always_comb begin
    if (digit_ok(m_i) && digit_ok(s_i))
      assert_digit_bcd_R8: assert (digit_ok(d_o));
  end
endmodule

// File: rtl/bcd_mc_array.sv
module bcd_mc_array
  import bcd_mc_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGIT_W * DIGITS
) (
  input  logic         sub_i,
  input  logic [W-1:0] m_i,
  input  logic [W-1:0] s_i,
  output logic [W-1:0] d_o,
  output logic         c_o
);
  logic [DIGITS:0] chain;
  assign chain[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_mc_digit u_digit (
      .sub_i (sub_i),
      .m_i   (m_i[g*DIGIT_W +: DIGIT_W]),
      .s_i   (s_i[g*DIGIT_W +: DIGIT_W]),
      .c_i   (chain[g]),
      .d_o   (d_o[g*DIGIT_W +: DIGIT_W]),
      .c_o   (chain[g+1])
    );
  end

  assign c_o = chain[DIGITS];
endmodule

// File: rtl/bcd_mc_sub.sv
module bcd_mc_sub
  import bcd_mc_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGIT_W * DIGITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sub,
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output logic [W-1:0] result,
  output logic         carry_flag
);
  logic [W-1:0] sum_d;
  logic         carry_d;

  bcd_mc_array #(.DIGITS(DIGITS)) u_array (
    .sub_i (sub),
    .m_i   (minuend),
    .s_i   (subtrahend),
    .d_o   (sum_d),
    .c_o   (carry_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      carry_flag <= 1'b0;
    end else begin
      result     <= sum_d;
      carry_flag <= carry_d;
    end
  end

  function automatic logic all_ok(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      ok = ok & digit_ok(v[i*DIGIT_W +: DIGIT_W]);
    return ok;
  endfunction

  logic in_ok;
  assign in_ok = all_ok(minuend) & all_ok(subtrahend);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result == '0 && !carry_flag));

  assert_borrow_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (sub && in_ok) |=> (carry_flag == ($past(subtrahend) > $past(minuend))));

  assert_equal_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (sub && in_ok && minuend == subtrahend) |=> (result == '0 && !carry_flag));

  assert_result_bcd_R8: assert property (@(posedge clk) disable iff (rst)
    in_ok |=> all_ok(result));
endmodule

// File: tb/bcd_mc_sub_tb.sv
`timescale 1ns/1ps
module bcd_mc_sub_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        sub4 = 1'b1;
  logic [15:0] m4 = '0, s4 = '0, r4;
  logic        f4;
  logic        sub1 = 1'b1;
  logic [3:0]  m1 = '0, s1 = '0, r1;
  logic        f1;

  bcd_mc_sub #(.DIGITS(4)) dut_i (
    .clk(clk), .rst(rst), .sub(sub4), .minuend(m4), .subtrahend(s4),
    .result(r4), .carry_flag(f4));

  bcd_mc_sub #(.DIGITS(1)) dut1_i (
    .clk(clk), .rst(rst), .sub(sub1), .minuend(m1), .subtrahend(s1),
    .result(r1), .carry_flag(f1));

  int checks = 0;
  int errors = 0;

  // {sub, minuend, subtrahend, expected result, expected flag}
  localparam int NV = 10;
  localparam logic [49:0] VEC [NV] = '{
    {1'b1, 16'h9876, 16'h1234, 16'h8642, 1'b0},
    {1'b1, 16'h1000, 16'h0001, 16'h0999, 1'b0},
    {1'b1, 16'h0001, 16'h0002, 16'h9999, 1'b1},
    {1'b1, 16'h5555, 16'h5555, 16'h0000, 1'b0},
    {1'b1, 16'h0000, 16'h9999, 16'h0001, 1'b1},
    {1'b1, 16'h1234, 16'h9876, 16'h1358, 1'b1},
    {1'b0, 16'h9999, 16'h0001, 16'h0000, 1'b1},
    {1'b0, 16'h4567, 16'h1234, 16'h5801, 1'b0},
    {1'b0, 16'h0999, 16'h0001, 16'h1000, 1'b0},
    {1'b1, 16'h9999, 16'h0000, 16'h9999, 1'b0}
  };

  function automatic int from_bcd(input logic [15:0] v);
    return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
  endfunction

  function automatic logic [15:0] to_bcd(input int n);
    logic [15:0] v;
    v[3:0]   = 4'(n % 10);
    v[7:4]   = 4'((n / 10) % 10);
    v[11:8]  = 4'((n / 100) % 10);
    v[15:12] = 4'((n / 1000) % 10);
    return v;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp,
                       input logic af, input logic ef);
    checks++;
    if (act !== exp || af !== ef) begin
      errors++;
      $display("FAIL %s: result=%h flag=%b expected result=%h flag=%b", req, act, af, exp, ef);
    end
  endtask

  task automatic apply4(input logic s, input logic [15:0] m, input logic [15:0] x);
    @(negedge clk);
    sub4 = s; m4 = m; s4 = x;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset with nonzero operands pending
    sub4 = 1'b0; m4 = 16'h9999; s4 = 16'h9999;
    sub1 = 1'b0; m1 = 4'h9; s1 = 4'h9;
    repeat (3) @(negedge clk);
    check("R1", r4, 16'h0000, f4, 1'b0);
    check("R1", {12'h0, r1}, 16'h0000, f1, 1'b0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      string req;
      v = VEC[i];
      apply4(v[49], v[48:33], v[32:17]);
      req = !v[49] ? "R6" : (v[0] ? "R4" : (v[48:33] == v[32:17] ? "R5" : "R3"));
      check(req, r4, v[16:1], f4, v[0]);
    end

    // R7: borrow across zero digits
    apply4(1'b1, 16'h1000, 16'h0001);
    check("R7", r4, 16'h0999, f4, 1'b0);
    apply4(1'b1, 16'h9000, 16'h0009);
    check("R7", r4, 16'h8991, f4, 1'b0);

    // R2: change inputs between edges, output holds until next edge
    @(negedge clk);
    sub4 = 1'b1; m4 = 16'h0005; s4 = 16'h0003;
    #1;
    check("R2", r4, 16'h8991, f4, 1'b0);
    @(negedge clk);
    check("R2", r4, 16'h0002, f4, 1'b0);

    // exhaustive single-digit build, both modes
    for (int md = 0; md < 2; md++) begin
      for (int a = 0; a < 10; a++) begin
        for (int b = 0; b < 10; b++) begin
          logic [3:0] er;
          logic ef;
          string req;
          @(negedge clk);
          sub1 = md[0]; m1 = 4'(a); s1 = 4'(b);
          @(negedge clk);
          if (md == 1) begin
            ef = b > a;
            er = ef ? 4'(10 - (b - a)) : 4'(a - b);
            req = ef ? "R4" : (a == b ? "R5" : "R3");
          end else begin
            ef = (a + b) >= 10;
            er = 4'((a + b) % 10);
            req = "R6";
          end
          check(req, {12'h0, r1}, {12'h0, er}, f1, ef);
          if (r1 > 4'd9) check("R8", {12'h0, r1}, 16'h0009, 1'b0, 1'b0);
        end
      end
    end

    // random four-digit vectors
    for (int k = 0; k < 300; k++) begin
      int a, b, exp_n;
      logic ds, ef;
      string req;
      a  = int'($urandom_range(9999));
      b  = (k % 7 == 0) ? a : int'($urandom_range(9999));
      ds = 1'($urandom_range(1));
      apply4(ds, to_bcd(a), to_bcd(b));
      if (ds) begin
        ef = b > a;
        exp_n = ef ? 10000 - (b - a) : a - b;
        req = ef ? "R4" : (a == b ? "R5" : "R3");
      end else begin
        ef = (a + b) >= 10000;
        exp_n = (a + b) % 10000;
        req = "R6";
      end
      check(req, r4, to_bcd(exp_n), f4, ef);
      for (int d = 0; d < 4; d++)
        if (r4[d*4 +: 4] > 4'd9) check("R8", {12'h0, r4[d*4 +: 4]}, 16'h0009, 1'b0, 1'b0);
      checks++; // R8 digit range check counted per vector
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule